// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block steps one coprocessor instruction through its exchange with an attached coprocessor. It handles five instruction classes: memory load into the coprocessor, memory store out of it, a register value moved into the coprocessor, a value moved out of it, and an internal coprocessor operation. After a start pulse it sends phase strobes to the coprocessor and reads the reply code. It runs the memory words of a transfer, and it ends every run with a single done pulse. A code on that pulse gives any exception the core must take.

While the coprocessor reports that it is busy, the sequencer keeps re-asking. Between two asks it spends one quiet cycle, and in that cycle it looks for a pending interrupt that is not masked. If it finds one, it sends an interrupt phase to the coprocessor and drops the instruction. No data moves in that case.

Top module: `cop_seq`

## Requirements
- R1: When `start` is accepted in idle, `ph_first` is high in the next cycle. After reset every strobe, `mem_req`, `done`, `exc_req` and `exc_code` are 0. Only one phase strobe is high in any cycle.
- R2: A busy reply (code 1) to a first or busy strobe is followed by exactly one cycle without strobes, then by a `ph_busy` strobe.
- R3: If a request is pending in that quiet cycle, `ph_intr` is pulsed and then `done` comes with an exception. No memory access or data phase happens. If no busy reply is given, the request lines are ignored.
- R4: The pending request is chosen in this order: reset request (code 5) first, then fast interrupt (code 6) unless `fiq_mask` is set, then interrupt (code 7) unless `irq_mask` is set.
- R5: A cannot reply (code 2) ends the run. Register moves and data operations get code 1 (undefined instruction). Loads and stores get code 2 (coprocessor abort).
- R6: For load and store, a go reply (code 3) is followed by `ph_xfer` and then by data cycles. The first word uses the start address. Each increment reply (code 4) in a data cycle adds 4 and moves one more word. Any other reply ends the loop. Loads pass `mem_rdata` to `cp_wdata`. Stores pass `cp_rdata` to `mem_wdata` with `mem_we` high.
- R7: A load or store gets code 3 (address exception) with no strobe, and `done` one cycle after start, in two cases. The first is a start address with any bit at or above `LEGAL_BITS` set. The second is a store whose address is below `VEC_LIMIT`. A load below `VEC_LIMIT` runs normally.
- R8: A successful move out of the coprocessor takes one coprocessor cycle, where `cp_rdata` is captured into `move_result`, and then one idle cycle. `done` follows three cycles after the accepting strobe. On a cannot reply, `move_result` holds `cond_flags` in its top four bits and zeros below.
- R9: A `mem_abort` seen in any data cycle raises code 4 only after the loop ends, and every word still moves.
- R10: The class and coprocessor number are latched at start. `cp_sel` and the run's behaviour ignore any change of `op_class`/`cop_num` until `done`.
- R11: `done` is a one-cycle pulse, once per run. `exc_req` is high only together with `done` and a non-zero code.
- R12: A move into the coprocessor drives the latched `move_src` on `cp_wdata` in its single coprocessor cycle (`ph_data` without `mem_req`). `done` follows two cycles after the accepting strobe. A data operation finishes one cycle after its go reply.

Class codes: 0 load, 1 store, 2 move in, 3 move out, 4 data operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted in idle) |
| op_class | input | 3 | Instruction class |
| cop_num | input | 4 | Coprocessor number |
| start_addr | input | AW | Transfer start address |
| move_src | input | DW | Value for a move into the coprocessor |
| cond_flags | input | 4 | Current condition flags |
| cp_resp | input | 3 | Coprocessor reply: 1 busy, 2 cannot, 3 go, 4 increment, 5 done |
| cp_rdata | input | DW | Data from the coprocessor |
| mem_rdata | input | DW | Memory read data |
| mem_abort | input | 1 | Memory abort for the current data cycle |
| rst_req | input | 1 | Reset request line |
| fiq_req | input | 1 | Fast interrupt request |
| fiq_mask | input | 1 | Fast interrupt mask |
| irq_req | input | 1 | Interrupt request |
| irq_mask | input | 1 | Interrupt mask |
| ph_first | output | 1 | First phase strobe |
| ph_busy | output | 1 | Busy re-ask strobe |
| ph_intr | output | 1 | Interrupt (abandon) strobe |
| ph_xfer | output | 1 | Transfer phase strobe |
| ph_data | output | 1 | Data / coprocessor cycle strobe |
| cp_sel | output | 4 | Latched coprocessor number |
| cp_wdata | output | DW | Data to the coprocessor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| move_result | output | DW | Result of a move out of the coprocessor |
| exc_req | output | 1 | Exception request (with done) |
| exc_code | output | 3 | Exception code |
| done | output | 1 | End-of-run pulse |

## Verification
The checker watches every cycle for the fixed strobe timing. It checks that the first strobe follows an accepted start, that a quiet cycle separates every busy re-ask from the strobe before it, and that an interrupt strobe leads straight to an excepting done. It also checks that consecutive data cycles step the address by 4, that the coprocessor number is steady mid-run, and that done is a single pulse carrying any exception. The bench scenarios are the only place that can show whether an outcome was the right one: the exception code chosen by priority and masks, the cannot mapping per class, the flag-only result, the deferred memory abort with a full word count, the address and vector exceptions, and the data routing for loads, stores and moves.

// File: rtl/cop_seq_pkg.sv
package cop_seq_pkg;

  localparam logic [2:0] CLS_LOAD     = 3'd0;
  localparam logic [2:0] CLS_STORE    = 3'd1;
  localparam logic [2:0] CLS_MOVE_IN  = 3'd2;
  localparam logic [2:0] CLS_MOVE_OUT = 3'd3;
  localparam logic [2:0] CLS_DATAOP   = 3'd4;

  localparam logic [2:0] RSP_BUSY = 3'd1;
  localparam logic [2:0] RSP_CANT = 3'd2;
  localparam logic [2:0] RSP_GO   = 3'd3;
  localparam logic [2:0] RSP_INC  = 3'd4;
  localparam logic [2:0] RSP_DONE = 3'd5;

  localparam logic [2:0] EXC_NONE  = 3'd0;
  localparam logic [2:0] EXC_UNDEF = 3'd1;
  localparam logic [2:0] EXC_CPABT = 3'd2;
  localparam logic [2:0] EXC_ADDR  = 3'd3;
  localparam logic [2:0] EXC_DABT  = 3'd4;
  localparam logic [2:0] EXC_RESET = 3'd5;
  localparam logic [2:0] EXC_FIQ   = 3'd6;
  localparam logic [2:0] EXC_IRQ   = 3'd7;

  typedef enum logic [3:0] {
    S_IDLE, S_FIRST, S_WAIT, S_BUSY, S_INTR,
    S_XFER, S_DATA, S_MVCYC, S_MVIDLE, S_FINISH
  } seq_state_e;

  function automatic logic is_mem(input logic [2:0] cls);
    return (cls == CLS_LOAD) || (cls == CLS_STORE);
  endfunction

endpackage

// File: rtl/cop_irq_arb.sv
module cop_irq_arb
  import cop_seq_pkg::*;
(
  input  logic       rst_req,
  input  logic       fiq_req,
  input  logic       fiq_mask,
  input  logic       irq_req,
  input  logic       irq_mask,
  output logic       pend,
  output logic [2:0] code
);
  logic fiq_live, irq_live;

  assign fiq_live = fiq_req & ~fiq_mask;
  assign irq_live = irq_req & ~irq_mask;
  assign pend     = rst_req | fiq_live | irq_live;

  always_comb begin
    if (rst_req)       code = EXC_RESET;
    else if (fiq_live) code = EXC_FIQ;
    else if (irq_live) code = EXC_IRQ;
    else               code = EXC_NONE;
  end
endmodule

// File: rtl/cop_addr_unit.sv
module cop_addr_unit
  import cop_seq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LEGAL_BITS = 26,
  parameter int VEC_LIMIT  = 32,
  parameter int STEP       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] start_addr,
  input  logic [2:0]    op_class,
  input  logic          load,
  input  logic          step,
  output logic          bad,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] VEC_TOP = AW'(VEC_LIMIT);
  localparam logic [AW-1:0] INC     = AW'(STEP);

  logic range_err;
  logic vec_hit;

  generate
    if (LEGAL_BITS < AW) begin : g_range
      assign range_err = |start_addr[AW-1:LEGAL_BITS];
    end else begin : g_norange
      assign range_err = 1'b0;
    end
  endgenerate

  assign vec_hit = (op_class == CLS_STORE) && (start_addr < VEC_TOP);
  assign bad     = is_mem(op_class) && (range_err || vec_hit);

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= start_addr;
    else if (step) addr <= addr + INC;
  end
endmodule

// File: rtl/cop_seq_fsm.sv
module cop_seq_fsm
  import cop_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [2:0] op_class,
  input  logic [2:0] cp_resp,
  input  logic       addr_bad,
  input  logic       irq_pend,
  input  logic [2:0] irq_code,
  input  logic       mem_abort,
  output logic       idle,
  output logic       addr_load,
  output logic       addr_step,
  output logic       cap_rd,
  output logic       cant_rd,
  output logic       ph_first,
  output logic       ph_busy,
  output logic       ph_intr,
  output logic       ph_xfer,
  output logic       ph_data,
  output logic       mem_req,
  output logic       mem_we,
  output logic       done,
  output logic       exc_req,
  output logic [2:0] exc_code
);
  seq_state_e st, st_d;
  logic [2:0] cls_q;
  logic [2:0] exc_q, exc_d;
  logic       ab_q, ab_d;

  always_comb begin
    st_d      = st;
    exc_d     = exc_q;
    ab_d      = ab_q;
    addr_load = 1'b0;
    addr_step = 1'b0;
    cap_rd    = 1'b0;
    cant_rd   = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (start) begin
          exc_d     = EXC_NONE;
          ab_d      = 1'b0;
          addr_load = 1'b1;
          if (addr_bad) begin
            exc_d = EXC_ADDR;
            st_d  = S_FINISH;
          end else begin
            st_d = S_FIRST;
          end
        end
      end
      S_FIRST, S_BUSY: begin
        if (cp_resp == RSP_BUSY) begin
          st_d = S_WAIT;
        end else if (cp_resp == RSP_CANT) begin
          st_d    = S_FINISH;
          exc_d   = is_mem(cls_q) ? EXC_CPABT : EXC_UNDEF;
          cant_rd = (cls_q == CLS_MOVE_OUT);
        end else if (is_mem(cls_q)) begin
          st_d = S_XFER;
        end else if (cls_q == CLS_DATAOP) begin
          st_d = S_FINISH;
        end else begin
          st_d = S_MVCYC;
        end
      end
      S_WAIT: begin
        if (irq_pend) begin
          st_d  = S_INTR;
          exc_d = irq_code;
        end else begin
          st_d = S_BUSY;
        end
      end
      S_INTR:   st_d = S_FINISH;
      S_XFER:   st_d = S_DATA;
      S_DATA: begin
        ab_d = ab_q | mem_abort;
        if (cp_resp == RSP_INC) begin
          addr_step = 1'b1;
        end else begin
          st_d = S_FINISH;
          if (ab_d) exc_d = EXC_DABT;
        end
      end
      S_MVCYC: begin
        if (cls_q == CLS_MOVE_OUT) begin
          cap_rd = 1'b1;
          st_d   = S_MVIDLE;
        end else begin
          st_d = S_FINISH;
        end
      end
      S_MVIDLE: st_d = S_FINISH;
      S_FINISH: st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      cls_q <= CLS_LOAD;
      exc_q <= EXC_NONE;
      ab_q  <= 1'b0;
    end else begin
      st    <= st_d;
      exc_q <= exc_d;
      ab_q  <= ab_d;
      if (st == S_IDLE && start) cls_q <= op_class;
    end
  end

  assign idle     = (st == S_IDLE);
  assign ph_first = (st == S_FIRST);
  assign ph_busy  = (st == S_BUSY);
  assign ph_intr  = (st == S_INTR);
  assign ph_xfer  = (st == S_XFER);
  assign ph_data  = (st == S_DATA) || (st == S_MVCYC);
  assign mem_req  = (st == S_DATA);
  assign mem_we   = (st == S_DATA) && (cls_q == CLS_STORE);
  assign done     = (st == S_FINISH);
  assign exc_code = exc_q;
  assign exc_req  = done && (exc_q != EXC_NONE);
endmodule

// File: rtl/cop_seq.sv
module cop_seq
  import cop_seq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LEGAL_BITS = 26,
  parameter int VEC_LIMIT  = 32,
  parameter int NUM_W      = 4,
  parameter int FLAG_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op_class,
  input  logic [NUM_W-1:0]  cop_num,
  input  logic [AW-1:0]     start_addr,
  input  logic [DW-1:0]     move_src,
  input  logic [FLAG_W-1:0] cond_flags,
  input  logic [2:0]        cp_resp,
  input  logic [DW-1:0]     cp_rdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_abort,
  input  logic              rst_req,
  input  logic              fiq_req,
  input  logic              fiq_mask,
  input  logic              irq_req,
  input  logic              irq_mask,
  output logic              ph_first,
  output logic              ph_busy,
  output logic              ph_intr,
  output logic              ph_xfer,
  output logic              ph_data,
  output logic [NUM_W-1:0]  cp_sel,
  output logic [DW-1:0]     cp_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [DW-1:0]     move_result,
  output logic              exc_req,
  output logic [2:0]        exc_code,
  output logic              done
);
  localparam int LOW_W = DW - FLAG_W;

  logic          seq_idle;
  logic          addr_load, addr_step, addr_bad;
  logic          cap_rd, cant_rd;
  logic          irq_pend;
  logic [2:0]    irq_code;
  logic [DW-1:0] src_q;

  cop_irq_arb u_arb (
    .rst_req  (rst_req),
    .fiq_req  (fiq_req),
    .fiq_mask (fiq_mask),
    .irq_req  (irq_req),
    .irq_mask (irq_mask),
    .pend     (irq_pend),
    .code     (irq_code)
  );

  cop_addr_unit #(
    .AW         (AW),
    .LEGAL_BITS (LEGAL_BITS),
    .VEC_LIMIT  (VEC_LIMIT)
  ) u_addr (
    .clk        (clk),
    .rst        (rst),
    .start_addr (start_addr),
    .op_class   (op_class),
    .load       (addr_load),
    .step       (addr_step),
    .bad        (addr_bad),
    .addr       (mem_addr)
  );

  cop_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op_class  (op_class),
    .cp_resp   (cp_resp),
    .addr_bad  (addr_bad),
    .irq_pend  (irq_pend),
    .irq_code  (irq_code),
    .mem_abort (mem_abort),
    .idle      (seq_idle),
    .addr_load (addr_load),
    .addr_step (addr_step),
    .cap_rd    (cap_rd),
    .cant_rd   (cant_rd),
    .ph_first  (ph_first),
    .ph_busy   (ph_busy),
    .ph_intr   (ph_intr),
    .ph_xfer   (ph_xfer),
    .ph_data   (ph_data),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .done      (done),
    .exc_req   (exc_req),
    .exc_code  (exc_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cp_sel      <= '0;
      src_q       <= '0;
      move_result <= '0;
    end else begin
      if (addr_load) begin
        cp_sel <= cop_num;
        src_q  <= move_src;
      end
      if (cap_rd)       move_result <= cp_rdata;
      else if (cant_rd) move_result <= {cond_flags, {LOW_W{1'b0}}};
    end
  end

  assign cp_wdata  = mem_req ? mem_rdata : src_q;
  assign mem_wdata = cp_rdata;
endmodule

// File: rtl/cop_seq_chk.sv
module cop_seq_chk #(
  parameter int AW    = 32,
  parameter int NUM_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             seq_idle,
  input logic             ph_first,
  input logic             ph_busy,
  input logic             ph_intr,
  input logic             ph_xfer,
  input logic             ph_data,
  input logic             mem_req,
  input logic [AW-1:0]    mem_addr,
  input logic [NUM_W-1:0] cp_sel,
  input logic             exc_req,
  input logic             done
);
  logic any_ph;
  assign any_ph = ph_first | ph_busy | ph_intr | ph_xfer | ph_data;

  a_r1_first_after_start: assert property (@(posedge clk) disable iff (rst)
    (start && seq_idle) |=> (ph_first || done));

  a_r1_one_phase: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ph_first, ph_busy, ph_intr, ph_xfer, ph_data}));

  a_r2_quiet_gap: assert property (@(posedge clk) disable iff (rst)
    ph_busy |-> (!$past(any_ph) && $past(ph_first || ph_busy, 2)));

  a_r3_intr_ends: assert property (@(posedge clk) disable iff (rst)
    ph_intr |=> (done && exc_req));

  a_r3_no_mem_on_intr: assert property (@(posedge clk) disable iff (rst)
    ph_intr |-> !mem_req);

  a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + AW'(4)));

  a_r10_sel_held: assert property (@(posedge clk) disable iff (rst)
    (ph_busy || ph_intr || ph_data || ph_xfer) |-> $stable(cp_sel));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_exc_with_done: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> done);
endmodule

bind cop_seq cop_seq_chk #(.AW(AW), .NUM_W(NUM_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .seq_idle (seq_idle),
  .ph_first (ph_first),
  .ph_busy  (ph_busy),
  .ph_intr  (ph_intr),
  .ph_xfer  (ph_xfer),
  .ph_data  (ph_data),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .cp_sel   (cp_sel),
  .exc_req  (exc_req),
  .done     (done)
);

// File: tb/cop_seq_bench.sv
module cop_seq_bench;
  localparam logic [31:0] MAGIC = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op_class = '0;
  logic [3:0]  cop_num = '0;
  logic [31:0] start_addr = '0;
  logic [31:0] move_src = '0;
  logic [3:0]  cond_flags = 4'b1010;
  logic [2:0]  cp_resp = '0;
  logic [31:0] cp_rdata = '0;
  logic [31:0] mem_rdata = '0;
  logic        mem_abort = 1'b0;
  logic        rst_req = 1'b0, fiq_req = 1'b0, fiq_mask = 1'b0;
  logic        irq_req = 1'b0, irq_mask = 1'b0;
  logic        ph_first, ph_busy, ph_intr, ph_xfer, ph_data;
  logic [3:0]  cp_sel;
  logic [31:0] cp_wdata, mem_addr, mem_wdata, move_result;
  logic        mem_req, mem_we, exc_req, done;
  logic [2:0]  exc_code;

  cop_seq u_cop_seq (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  logic [2:0]  script [16];
  int sidx, abort_at;
  logic [31:0] cop_val;
  int cyc = 0, t_start, t_first, t_busy0, t_done;
  int n_first, n_busy, n_intr, n_mem, n_wr, n_done, data_bad, exc_stray;
  logic [31:0] alog [16];
  logic [31:0] mv_wdata, got_res;
  logic [2:0]  got_exc;
  logic [3:0]  got_sel;

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int i);
    return base + 32'(4 * i);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic prep(input int b, input logic [2:0] main, input int k);
    int p = 0;
    for (int i = 0; i < 16; i++) script[i] = 3'd5;
    for (int i = 0; i < b; i++) begin script[p] = 3'd1; p++; end
    script[p] = main; p++;
    for (int i = 0; i < k; i++) begin script[p] = 3'd4; p++; end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (ph_first || ph_busy || (ph_data && mem_req)) begin
        cp_resp = (sidx < 16) ? script[sidx] : 3'd5;
        sidx++;
      end else cp_resp = 3'd0;
      mem_rdata = mem_addr ^ MAGIC;
      mem_abort = mem_req && (n_mem == abort_at);
      cp_rdata  = cop_val;
      #1;
      cyc++;
      if (start) t_start = cyc;
      if (ph_first) begin n_first++; t_first = cyc; end
      if (ph_busy) begin if (n_busy == 0) t_busy0 = cyc; n_busy++; end
      if (ph_intr) n_intr++;
      if (exc_req && !done) exc_stray++;
      if (mem_req) begin
        if (n_mem < 16) alog[n_mem] = mem_addr;
        if (mem_we) begin
          n_wr++;
          if (mem_wdata !== cp_rdata) data_bad++;
        end else if (cp_wdata !== mem_rdata) data_bad++;
        n_mem++;
      end
      if (ph_data && !mem_req) mv_wdata = cp_wdata;
      if (done) begin
        n_done++; t_done = cyc; got_exc = exc_code;
        got_res = move_result; got_sel = cp_sel;
      end
    end
  end

  task automatic go(input logic [2:0] cls, input logic [31:0] addr, input logic [3:0] num);
    sidx = 0; n_first = 0; n_busy = 0; n_intr = 0; n_mem = 0; n_wr = 0;
    n_done = 0; data_bad = 0; exc_stray = 0;
    t_start = -1; t_first = -1; t_busy0 = -1; t_done = -1;
    @(negedge clk);
    op_class = cls; start_addr = addr; cop_num = num; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_class = 3'd7; cop_num = ~num; start_addr = '1;
    for (int w = 0; w < 300 && n_done == 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_done == 1, "R11 single done pulse", 32'(n_done), 32'd1);
    chk(exc_stray == 0, "R11 exc_req only with done", 32'(exc_stray), 32'd0);
  endtask

  task automatic mem_run(input logic [2:0] cls, input logic [31:0] a, input int b, input int k,
                         input int ab, input logic [2:0] ex);
    abort_at = ab; cop_val = 32'hC0DE_0000 + 32'(k);
    prep(b, 3'd3, k);
    go(cls, a, 4'h3);
    chk(t_first == t_start + 1, "R1 first strobe one cycle after start", 32'(t_first), 32'(t_start + 1));
    chk(n_busy == b, "R2 busy re-asks", 32'(n_busy), 32'(b));
    if (b > 0) chk(t_busy0 == t_first + 2, "R2 quiet cycle before busy strobe", 32'(t_busy0), 32'(t_first + 2));
    chk(n_mem == k + 1, "R6 word count", 32'(n_mem), 32'(k + 1));
    for (int i = 0; i <= k && i < 16; i++)
      chk(alog[i] == exp_addr(a, i), "R6 post-indexed address", alog[i], exp_addr(a, i));
    chk(n_wr == ((cls == 3'd1) ? k + 1 : 0), "R6 write enables", 32'(n_wr), 32'((cls == 3'd1) ? k + 1 : 0));
    chk(data_bad == 0, "R6 data routing", 32'(data_bad), 32'd0);
    chk(got_exc == ex, "R9 exception after transfer", 32'(got_exc), 32'(ex));
  endtask

  task automatic irq_run(input logic r, input logic f, input logic fm, input logic i, input logic im,
                         input logic [2:0] ex);
    rst_req = r; fiq_req = f; fiq_mask = fm; irq_req = i; irq_mask = im;
    abort_at = -1; prep(2, 3'd3, 0);
    go(3'd0, 32'h200, 4'h5);
    rst_req = 0; fiq_req = 0; fiq_mask = 0; irq_req = 0; irq_mask = 0;
    chk(got_exc == ex, "R4 request priority and masks", 32'(got_exc), 32'(ex));
    if (ex != 3'd0) begin
      chk(n_intr == 1, "R3 interrupt strobe sent", 32'(n_intr), 32'd1);
      chk(n_mem == 0, "R3 no memory after abandon", 32'(n_mem), 32'd0);
      chk(n_busy == 0, "R3 no busy re-ask after abandon", 32'(n_busy), 32'd0);
    end else begin
      chk(n_mem == 1, "R4 masked request runs through", 32'(n_mem), 32'd1);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    abort_at = -1; cop_val = 0;
    repeat (3) @(negedge clk);
    chk({ph_first, ph_busy, ph_intr, ph_xfer, ph_data, mem_req, done, exc_req} == 8'd0,
        "R1 reset state strobes", 32'({ph_first, ph_busy, ph_intr, ph_xfer, ph_data, mem_req, done, exc_req}), 32'd0);
    chk(exc_code == 3'd0, "R1 reset exc_code", 32'(exc_code), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    mem_run(3'd0, 32'h0000_1000, 0, 0, -1, 3'd0);
    mem_run(3'd1, 32'h0000_2000, 2, 3, -1, 3'd0);
    mem_run(3'd0, 32'h0000_3000, 1, 3, 1, 3'd4);   // R9 abort on word 1
    mem_run(3'd1, 32'h0000_3100, 0, 2, 2, 3'd4);   // R9 abort on last word

    // R5 cannot mapping
    for (int c = 0; c < 5; c++) begin
      abort_at = -1; prep(1, 3'd2, 0);
      go(3'(c), 32'h400, 4'h1);
      chk(got_exc == ((c < 2) ? 3'd2 : 3'd1), "R5 cannot exception", 32'(got_exc), (c < 2) ? 32'd2 : 32'd1);
      chk(n_mem == 0, "R5 no transfer on cannot", 32'(n_mem), 32'd0);
      if (c == 3) chk(got_res == 32'hA000_0000, "R8 flags-only result on cannot", got_res, 32'hA000_0000);
    end

    // R8 move out success
    cop_val = 32'h1234_5678; prep(0, 3'd3, 0);
    go(3'd3, 32'h0, 4'h9);
    chk(got_res == 32'h1234_5678, "R8 captured result", got_res, 32'h1234_5678);
    chk(t_done == t_first + 3, "R8 coprocessor then idle cycle", 32'(t_done), 32'(t_first + 3));
    chk(got_exc == 3'd0, "R8 no exception", 32'(got_exc), 32'd0);

    // R12 move in, data op
    move_src = 32'hFEED_BEEF; prep(1, 3'd3, 0);
    go(3'd2, 32'h0, 4'h2);
    move_src = 32'h0;
    chk(mv_wdata == 32'hFEED_BEEF, "R12 move source on cp_wdata", mv_wdata, 32'hFEED_BEEF);
    chk(t_done == t_busy0 + 2, "R12 move in done timing", 32'(t_done), 32'(t_busy0 + 2));
    prep(0, 3'd3, 0);
    go(3'd4, 32'h0, 4'h4);
    chk(t_done == t_first + 1, "R12 data op done timing", 32'(t_done), 32'(t_first + 1));
    chk(n_mem == 0 && got_exc == 3'd0, "R12 data op no memory", 32'(n_mem), 32'd0);

    // R3/R4 interrupts during busy-wait
    irq_run(1, 1, 0, 1, 0, 3'd5);
    irq_run(0, 1, 0, 1, 0, 3'd6);
    irq_run(0, 1, 1, 1, 0, 3'd7);
    irq_run(0, 1, 1, 1, 1, 3'd0);
    // R3 request ignored without busy reply
    irq_req = 1; prep(0, 3'd3, 0);
    go(3'd0, 32'h300, 4'h6);
    irq_req = 0;
    chk(n_intr == 0 && got_exc == 3'd0, "R3 no busy, request ignored", 32'(got_exc), 32'd0);
    chk(n_mem == 1, "R3 transfer proceeds", 32'(n_mem), 32'd1);

    // R7 address checks
    prep(0, 3'd3, 0);
    go(3'd0, 32'h0400_0000, 4'h1);
    chk(got_exc == 3'd3 && n_first == 0, "R7 out of range", 32'(got_exc), 32'd3);
    chk(t_done == t_start + 1, "R7 done timing", 32'(t_done), 32'(t_start + 1));
    go(3'd1, 32'h0000_0010, 4'h1);
    chk(got_exc == 3'd3 && n_mem == 0, "R7 store to vector area", 32'(got_exc), 32'd3);
    mem_run(3'd0, 32'h0000_0010, 0, 1, -1, 3'd0);  // R7 load from vector area runs

    // R10 latched class and number
    cop_val = 32'h7777_0000; prep(0, 3'd3, 1);
    go(3'd1, 32'h800, 4'hB);
    chk(got_sel == 4'hB, "R10 coprocessor number held", 32'(got_sel), 32'hB);
    chk(n_wr == 2, "R10 class held as store", 32'(n_wr), 32'd2);

    // R6 random transfers
    for (int it = 0; it < 30; it++) begin
      logic [2:0]  cls;
      logic [31:0] a;
      cls = 3'($urandom % 2);
      a   = 32'h100 + (($urandom % 32'h10000) << 2);
      mem_run(cls, a, int'($urandom % 3), int'($urandom % 5), -1, 3'd0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule